// File: doc/BRIEF.md
# VPD Serial EEPROM Bridge

This block gives a host two registers through which four bytes of vital product data are moved to or from a small 16-bit-wide serial EEPROM with a chip-select, clock, data-in and data-out wiring. The first register is a control word: a word-address field in its low bits and a direction/completion flag in bit 31. The second register is a 32-bit data holder.

The host starts a transfer by writing the control word once, with the flag and the address together. A flag of 1 asks the bridge to store the data holder into the EEPROM. A flag of 0 asks it to fill the data holder from the EEPROM. The bridge signals the end of the transfer by flipping the flag to its opposite value, so software polls for 0 after a store and for 1 after a fetch. Each transfer covers two EEPROM words at consecutive addresses, with the low half of the data holder at the lower address.

The serial clock comes from dividing the system clock by a parameter. Before a store the bridge issues a write-enable command, and after every stored word it keeps chip select high and waits for the EEPROM to report ready on its data-out line.

Top module: `vpd_eeprom_bridge`

## Requirements
- R1: After reset the control word and the data holder both read 0, and eeCs, eeSk and eeDi are low.
- R2: A control-word write with bit 31 = 0 while idle fetches EEPROM words A and A+1, where A is bits [ADDR_W-1:0] of the written value; the data holder then reads {word A+1, word A} and bit 31 of the control word reads 1.
- R3: A control-word write with bit 31 = 1 while idle first sends the write-enable command (start 1, opcode 00, address field with its two top bits 11), then stores data holder bits [15:0] at A and bits [31:16] at A+1; bit 31 then reads 0.
- R4: Every read or store command is start bit 1, opcode (10 fetch, 01 store), the 6-bit address MSB first, then 16 data bits MSB first; eeDo is sampled on each falling eeSk edge and the fetched word is the 16 samples after the address.
- R5: eeSk stays high for CLK_DIV system cycles and low for CLK_DIV cycles within a command, toggles only while eeCs is high, and eeDi changes only while eeSk is low.
- R6: After each stored word the bridge raises eeCs again and issues no further serial clock until eeDo reads 1.
- R7: While a transfer is in progress, host writes to either register are ignored: the address field, the flag and the data holder keep their values and the transfer uses the original address.
- R8: From the accepting write until completion, bit 31 reads the value the host wrote and the address field reads the written address.
- R9: A host write to the data holder while idle is visible on the data read port in the next cycle.
- R10: The second word address wraps modulo 2^ADDR_W, so A = 63 pairs with word 0.
- R11: Between consecutive commands eeCs stays low for at least CLK_DIV system cycles, and it is low whenever no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Host register write strobe |
| regSel | input | 1 | Register select: 0 control word, 1 data holder |
| regWdata | input | 32 | Host write data |
| addrWord | output | 32 | Control word readback: flag in bit 31, address in low bits |
| dataWord | output | 32 | Data holder readback |
| eeCs | output | 1 | EEPROM chip select |
| eeSk | output | 1 | EEPROM serial clock |
| eeDi | output | 1 | Serial data toward the EEPROM |
| eeDo | input | 1 | Serial data / ready from the EEPROM |

## Verification
The bench drives a behavioural EEPROM that decodes each command bit by bit, so a wrong opcode, a swapped word order or a missing write-enable shows up as wrong memory contents or wrong fetched data. It stretches the EEPROM busy time and counts any serial clock issued before ready, catching a bridge that skips the poll. It fires control and data writes in the middle of a fetch; a bridge that accepts them would redirect the transfer or corrupt the data holder. The top address is used for both directions to catch an address that carries into a seventh bit instead of wrapping, and a timing monitor flags shortened clock phases, too-short chip-select gaps and data changing while the clock is high.

// File: rtl/vpd_bridge_pkg.sv
package vpd_bridge_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_EWEN,
    ST_EWEN_GAP,
    ST_XFER,
    ST_XFER_GAP,
    ST_POLL,
    ST_POLL_GAP,
    ST_DONE
  } vpdState_t;

  // Strobes from the sequencer to the datapath; every load and chip-select
  // change is issued on a divider tick.
  typedef struct packed {
    logic loadEwen;
    logic loadRead;
    logic loadWrite;
    logic wordHi;
    logic shiftEn;
    logic csOn;
    logic csOff;
    logic captureLo;
    logic captureHi;
    logic finish;
  } vpdStrobe_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_EXT   = 2'b00;

endpackage

// File: rtl/vpd_ctrl.sv
module vpd_ctrl
  import vpd_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostStart,
  input  logic       isWrite,
  input  logic       tick,
  input  logic       bitsDone,
  input  logic       doSync,
  output vpdStrobe_t strobe,
  output logic       idle
);

  vpdState_t state, stateNxt;
  logic wordHi, wordHiNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      wordHi <= 1'b0;
    end else begin
      state  <= stateNxt;
      wordHi <= wordHiNxt;
    end
  end

  always_comb begin
    stateNxt      = state;
    wordHiNxt     = wordHi;
    strobe        = '0;
    strobe.wordHi = wordHi;
    unique case (state)
      ST_IDLE: begin
        if (hostStart) stateNxt = ST_START;
      end
      ST_START: begin
        if (tick) begin
          if (isWrite) begin
            strobe.loadEwen = 1'b1;
            stateNxt        = ST_EWEN;
          end else begin
            strobe.loadRead = 1'b1;
            stateNxt        = ST_XFER;
          end
        end
      end
      ST_EWEN: begin
        if (!bitsDone) begin
          strobe.shiftEn = 1'b1;
        end else if (tick) begin
          strobe.csOff = 1'b1;
          stateNxt     = ST_EWEN_GAP;
        end
      end
      ST_EWEN_GAP: begin
        if (tick) begin
          strobe.loadWrite = 1'b1;
          stateNxt         = ST_XFER;
        end
      end
      ST_XFER: begin
        if (!bitsDone) begin
          strobe.shiftEn = 1'b1;
        end else if (tick) begin
          strobe.csOff     = 1'b1;
          strobe.captureLo = !isWrite && !wordHi;
          strobe.captureHi = !isWrite && wordHi;
          stateNxt         = ST_XFER_GAP;
        end
      end
      ST_XFER_GAP: begin
        if (tick) begin
          if (isWrite) begin
            strobe.csOn = 1'b1;
            stateNxt    = ST_POLL;
          end else if (!wordHi) begin
            wordHiNxt       = 1'b1;
            strobe.wordHi   = 1'b1;
            strobe.loadRead = 1'b1;
            stateNxt        = ST_XFER;
          end else begin
            stateNxt = ST_DONE;
          end
        end
      end
      ST_POLL: begin
        if (tick && doSync) begin
          strobe.csOff = 1'b1;
          stateNxt     = ST_POLL_GAP;
        end
      end
      ST_POLL_GAP: begin
        if (tick) begin
          if (!wordHi) begin
            wordHiNxt        = 1'b1;
            strobe.wordHi    = 1'b1;
            strobe.loadWrite = 1'b1;
            stateNxt         = ST_XFER;
          end else begin
            stateNxt = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        strobe.finish = 1'b1;
        wordHiNxt     = 1'b0;
        stateNxt      = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign idle = (state == ST_IDLE);

endmodule

// File: rtl/vpd_datapath.sv
module vpd_datapath
  import vpd_bridge_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regSel,
  input  logic [31:0]       regWdata,
  input  vpdStrobe_t        strobe,
  input  logic              ctrlIdle,
  output logic [31:0]       addrWord,
  output logic [31:0]       dataWord,
  output logic              hostStart,
  output logic              isWrite,
  output logic              tick,
  output logic              bitsDone,
  output logic              doSync,
  output logic              eeCs,
  output logic              eeSk,
  output logic              eeDi,
  input  logic              eeDo
);

  localparam int WORD_W  = 16;
  localparam int FRAME_W = 3 + ADDR_W + WORD_W;
  localparam int EWEN_W  = 3 + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int DIV_W   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  // Serial clock divider: one tick per half period of eeSk.
  logic [DIV_W-1:0] divCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                                divCnt <= '0;
    else if (divCnt == DIV_W'(CLK_DIV - 1))   divCnt <= '0;
    else                                      divCnt <= divCnt + 1'b1;
  end
  assign tick = (divCnt == DIV_W'(CLK_DIV - 1));

  // Host-visible registers.
  logic              flag;
  logic [ADDR_W-1:0] addrReg;
  logic [31:0]       dataReg;
  logic [WORD_W-1:0] rxShift;

  assign hostStart = regWe && !regSel && ctrlIdle;
  assign isWrite   = flag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag    <= 1'b0;
      addrReg <= '0;
    end else if (hostStart) begin
      flag    <= regWdata[31];
      addrReg <= regWdata[ADDR_W-1:0];
    end else if (strobe.finish) begin
      flag    <= ~flag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                   dataReg <= '0;
    else if (regWe && regSel && ctrlIdle)        dataReg <= regWdata;
    else if (strobe.captureLo)                   dataReg[15:0]  <= rxShift;
    else if (strobe.captureHi)                   dataReg[31:16] <= rxShift;
  end

  assign addrWord = {flag, {(31 - ADDR_W){1'b0}}, addrReg};
  assign dataWord = dataReg;

  // Input synchronizer for the EEPROM data-out line.
  logic doMeta;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doMeta <= 1'b0;
      doSync <= 1'b0;
    end else begin
      doMeta <= eeDo;
      doSync <= doMeta;
    end
  end

  // Frame builder.
  logic [ADDR_W-1:0] wordAddr;
  logic [WORD_W-1:0] wordData;
  assign wordAddr = addrReg + ADDR_W'(strobe.wordHi);
  assign wordData = strobe.wordHi ? dataReg[31:16] : dataReg[15:0];

  logic [FRAME_W-1:0] frameRead, frameWrite, frameEwen;
  assign frameRead  = {1'b1, OP_READ,  wordAddr, {WORD_W{1'b0}}};
  assign frameWrite = {1'b1, OP_WRITE, wordAddr, wordData};
  assign frameEwen  = {1'b1, OP_EXT, 2'b11, {(ADDR_W - 2){1'b0}}, {WORD_W{1'b0}}};

  // Shift engine.
  logic [FRAME_W-1:0] txShift;
  logic [CNT_W-1:0]   bitsLeft;
  logic               csReg, skReg;
  logic               anyLoad;
  assign anyLoad = strobe.loadEwen || strobe.loadRead || strobe.loadWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift  <= '0;
      bitsLeft <= '0;
      skReg    <= 1'b0;
      rxShift  <= '0;
    end else if (anyLoad) begin
      skReg <= 1'b0;
      if (strobe.loadEwen) begin
        txShift  <= frameEwen;
        bitsLeft <= CNT_W'(EWEN_W);
      end else if (strobe.loadRead) begin
        txShift  <= frameRead;
        bitsLeft <= CNT_W'(FRAME_W);
      end else begin
        txShift  <= frameWrite;
        bitsLeft <= CNT_W'(FRAME_W);
      end
    end else if (strobe.shiftEn && tick && !bitsDone) begin
      if (!skReg) begin
        skReg <= 1'b1;
      end else begin
        skReg    <= 1'b0;
        txShift  <= {txShift[FRAME_W-2:0], 1'b0};
        rxShift  <= {rxShift[WORD_W-2:0], doSync};
        bitsLeft <= bitsLeft - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       csReg <= 1'b0;
    else if (anyLoad || strobe.csOn) csReg <= 1'b1;
    else if (strobe.csOff)           csReg <= 1'b0;
  end

  assign bitsDone = (bitsLeft == '0);
  assign eeCs     = csReg;
  assign eeSk     = skReg;
  assign eeDi     = csReg && txShift[FRAME_W-1];

endmodule

// File: rtl/vpd_eeprom_bridge.sv
module vpd_eeprom_bridge
  import vpd_bridge_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regSel,
  input  logic [31:0] regWdata,
  output logic [31:0] addrWord,
  output logic [31:0] dataWord,
  output logic        eeCs,
  output logic        eeSk,
  output logic        eeDi,
  input  logic        eeDo
);

  vpdStrobe_t strobe;
  logic hostStart, isWrite, tick, bitsDone, doSync, idle, busy;

  assign busy = !idle;

  vpd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostStart (hostStart),
    .isWrite   (isWrite),
    .tick      (tick),
    .bitsDone  (bitsDone),
    .doSync    (doSync),
    .strobe    (strobe),
    .idle      (idle)
  );

  vpd_datapath #(
    .CLK_DIV (CLK_DIV),
    .ADDR_W  (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regSel    (regSel),
    .regWdata  (regWdata),
    .strobe    (strobe),
    .ctrlIdle  (idle),
    .addrWord  (addrWord),
    .dataWord  (dataWord),
    .hostStart (hostStart),
    .isWrite   (isWrite),
    .tick      (tick),
    .bitsDone  (bitsDone),
    .doSync    (doSync),
    .eeCs      (eeCs),
    .eeSk      (eeSk),
    .eeDi      (eeDi),
    .eeDo      (eeDo)
  );

endmodule

// File: rtl/vpd_bridge_checker.sv
module vpd_bridge_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              eeCs,
  input logic              eeSk,
  input logic              eeDi,
  input logic              busy,
  input logic              flag,
  input logic [ADDR_W-1:0] addrField
);

  assert_di_sk_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(eeDi) |-> !eeSk);

  assert_sk_needs_cs_R5: assert property (@(posedge clk) disable iff (!rstN)
    !eeCs |-> !eeSk);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(flag));

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(addrField));

  assert_done_flips_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (flag != $past(flag)));

  assert_idle_cs_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !eeCs);

endmodule

bind vpd_eeprom_bridge vpd_bridge_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .eeCs      (eeCs),
  .eeSk      (eeSk),
  .eeDi      (eeDi),
  .busy      (busy),
  .flag      (addrWord[31]),
  .addrField (addrWord[ADDR_W-1:0])
);

// File: tb/tb_vpd_eeprom_bridge.sv
module tb_vpd_eeprom_bridge;

  localparam int CLK_DIV = 4;
  localparam int ADDR_W  = 6;
  localparam int BUSY    = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic regSel = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] addrWord, dataWord;
  logic eeCs, eeSk, eeDi, eeDo;

  always #2 clk = ~clk;

  vpd_eeprom_bridge #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .addrWord(addrWord), .dataWord(dataWord),
    .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .eeDo(eeDo)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // ---------------- behavioural EEPROM ----------------
  logic [15:0] mem [64];
  int bitCnt = 0;
  logic [24:0] rxBits = '0;
  logic [1:0] cmdOp = 2'b11;
  logic [5:0] cmdAddr = '0;
  logic ewen = 1'b0;
  logic doDrv = 1'b0;
  int cycle = 0;
  int writeCycle = -100000;
  int earlyClocks = 0;
  int noEwenWrites = 0;
  int badStart = 0;
  logic ready;

  always @(posedge clk) cycle <= cycle + 1;
  assign ready = (cycle - writeCycle) >= BUSY;
  assign eeDo = eeCs && ((cmdOp == 2'b10 && bitCnt >= 10) ? doDrv : ready);

  always @(posedge eeCs) begin
    bitCnt = 0;
    rxBits = '0;
    cmdOp  = 2'b11;
  end

  always @(posedge eeSk) begin
    if (eeCs) begin
      if (!ready) earlyClocks++;
      bitCnt++;
      rxBits = {rxBits[23:0], eeDi};
      if (bitCnt == 9) begin
        if (rxBits[8] != 1'b1) badStart++;
        cmdOp   = rxBits[7:6];
        cmdAddr = rxBits[5:0];
        if (cmdOp == 2'b00 && cmdAddr[5:4] == 2'b11) ewen = 1'b1;
      end
      if (cmdOp == 2'b10 && bitCnt >= 10 && bitCnt <= 25) begin
        int idx;
        idx = 25 - bitCnt;
        doDrv = mem[cmdAddr][idx];
      end
    end
  end

  always @(negedge eeCs) begin
    if (bitCnt == 25 && cmdOp == 2'b01) begin
      if (ewen) begin
        mem[cmdAddr] = rxBits[15:0];
        writeCycle = cycle;
      end else begin
        noEwenWrites++;
      end
    end
    doDrv = 1'b0;
  end

  // ---------------- serial timing monitor ----------------
  int highCnt = 0, lowCnt = 0, gapCnt = 0;
  int skErr = 0, diErr = 0, gapErr = 0;
  logic prevSk = 0, prevCs = 0, prevDi = 0;
  bit seenFall = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (eeSk && !eeCs) skErr++;
      if (eeSk && (eeDi != prevDi)) diErr++;
      if (eeSk) highCnt++;
      if (!eeSk && prevSk) begin
        if (highCnt != CLK_DIV) skErr++;
        highCnt = 0;
      end
      if (eeCs && !eeSk) lowCnt++;
      if (!eeCs) lowCnt = 0;
      if (eeSk && !prevSk) begin
        if (lowCnt != CLK_DIV) skErr++;
        lowCnt = 0;
      end
      if (!eeCs) gapCnt++;
      if (!eeCs && prevCs) seenFall = 1;
      if (eeCs && !prevCs) begin
        if (seenFall && gapCnt < CLK_DIV) gapErr++;
        gapCnt = 0;
      end
    end
    prevSk = eeSk;
    prevCs = eeCs;
    prevDi = eeDi;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic sel, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1;
    regSel = sel;
    regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitFlag(input logic exp, output int cycles);
    cycles = 0;
    while (addrWord[31] !== exp && cycles < 6000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset;
    check(addrWord == 32'h0, "R1 control word", addrWord, 32'h0);
    check(dataWord == 32'h0, "R1 data holder", dataWord, 32'h0);
    check({eeCs, eeSk, eeDi} == 3'b000, "R1 serial pins", {29'h0, eeCs, eeSk, eeDi}, 32'h0);
  endtask

  task automatic testDataWrite;
    hostWrite(1'b1, 32'h1234_5678);
    check(dataWord == 32'h1234_5678, "R9 data write idle", dataWord, 32'h1234_5678);
  endtask

  task automatic testRead;
    int cyc;
    mem[10] = 16'hA1B2;
    mem[11] = 16'hC3D4;
    hostWrite(1'b0, 32'h0000_000A);
    check(addrWord == 32'h0000_000A, "R8 flag and address while fetching", addrWord, 32'h0000_000A);
    waitFlag(1'b1, cyc);
    check(addrWord[31] == 1'b1, "R2 fetch completion flag", {31'h0, addrWord[31]}, 32'h1);
    check(dataWord == 32'hC3D4_A1B2, "R2 R4 fetched data", dataWord, 32'hC3D4_A1B2);
  endtask

  task automatic testWrite;
    int cyc;
    hostWrite(1'b1, 32'hCAFE_F00D);
    hostWrite(1'b0, 32'h8000_0014);
    check(addrWord == 32'h8000_0014, "R8 flag held during store", addrWord, 32'h8000_0014);
    waitFlag(1'b0, cyc);
    check(addrWord[31] == 1'b0, "R3 store completion flag", {31'h0, addrWord[31]}, 32'h0);
    check(mem[20] == 16'hF00D, "R3 low word stored", {16'h0, mem[20]}, 32'hF00D);
    check(mem[21] == 16'hCAFE, "R3 high word stored", {16'h0, mem[21]}, 32'hCAFE);
    check(ewen && noEwenWrites == 0, "R3 write enable issued first", noEwenWrites, 0);
    check(earlyClocks == 0, "R6 no clock while busy", earlyClocks, 0);
    check(cyc >= 2 * BUSY, "R6 completion waits for ready", cyc, 2 * BUSY);
  endtask

  task automatic testIgnore;
    int cyc;
    mem[30] = 16'h1111;
    mem[31] = 16'h2222;
    hostWrite(1'b0, 32'h0000_001E);
    repeat (20) @(negedge clk);
    hostWrite(1'b0, 32'h8000_0005);
    hostWrite(1'b1, 32'hDEAD_BEEF);
    check(addrWord == 32'h0000_001E, "R7 control write ignored", addrWord, 32'h0000_001E);
    check(dataWord == 32'hCAFE_F00D, "R7 data write ignored", dataWord, 32'hCAFE_F00D);
    waitFlag(1'b1, cyc);
    check(dataWord == 32'h2222_1111, "R7 original transfer completes", dataWord, 32'h2222_1111);
    check(mem[5] == 16'h0, "R7 no stray store", {16'h0, mem[5]}, 32'h0);
  endtask

  task automatic testWrap;
    int cyc;
    mem[63] = 16'hABCD;
    mem[0]  = 16'h0123;
    hostWrite(1'b0, 32'h0000_003F);
    waitFlag(1'b1, cyc);
    check(dataWord == 32'h0123_ABCD, "R10 fetch wraps", dataWord, 32'h0123_ABCD);
    hostWrite(1'b1, 32'h5566_7788);
    hostWrite(1'b0, 32'h8000_003F);
    waitFlag(1'b0, cyc);
    check(mem[63] == 16'h7788, "R10 store low at top", {16'h0, mem[63]}, 32'h7788);
    check(mem[0] == 16'h5566, "R10 store high wraps", {16'h0, mem[0]}, 32'h5566);
    check(badStart == 0, "R4 start bit present", badStart, 0);
  endtask

  task automatic testTiming;
    check(skErr == 0, "R5 clock phase length", skErr, 0);
    check(diErr == 0, "R5 data stable while clock high", diErr, 0);
    check(gapErr == 0, "R11 chip select gap", gapErr, 0);
    check(eeCs == 1'b0, "R11 chip select idle low", {31'h0, eeCs}, 32'h0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDataWrite();
    testRead();
    testWrite();
    testIgnore();
    testWrap();
    testTiming();
    finished = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

endmodule